// File: doc/BRIEF.md
# Status Register Write Controller

This block owns the processor's current status word and one saved status word for each exception bank. Status-register move operations update it. Each write carries a 4-bit field mask and a 32-bit data word. The mode held in the current status word decides how far the write may reach, and which saved word a saved-status write lands in. The block drives the condition flags, the two interrupt-disable bits, the thumb bit and the 5-bit mode field.

Each write takes effect on the clock edge that samples its strobe. If a current-status write alters the mode field, the block raises a one-cycle mode-change request and also presents the previous mode, so the register file can swap its banked registers. A configuration input selects legacy 26-bit operation. While it is low, every current-status write is cut down to the bits that the 26-bit layout keeps.

Saved-status reads are combinational and use a separate mode select. A mode that has no saved word reads back the current status word instead. If both strobes are high in the same cycle, the saved-status write uses the mode that was in force before the edge.

Top module: `psr_ctrl`

## Requirements
- R1: After reset the current status word is 0x000000D3 (supervisor mode 10011, both interrupt-disable bits set), the mode-change request is low and every saved word reads 0.
- R2: In a privileged mode, a current-status write with field mask 4'b1001 replaces all 32 bits at the next clock edge. Without a write strobe the word holds.
- R3: In a privileged mode, with any other mask, mask bit 0 writes bits 7:0 and mask bit 3 writes bits 31:24. Bits 23:8 and mask bits 1 and 2 have no effect.
- R4: In the user bank (mode 10000 or 00000), a current-status write changes only bits 31:24, whatever the mask is.
- R5: When prog32_i is low, the value a current-status write leaves is ANDed with 0xF00000C3. Only flags 31:28, interrupt bits 7:6 and mode bits 1:0 survive.
- R6: mode_chg_o is high for exactly the cycle after a current-status write that changed bits 4:0. In that cycle old_mode_o holds the previous mode. Otherwise mode_chg_o is low.
- R7: A saved-status write goes to the saved word of the current mode's bank. It uses the privileged mask rules of R2 and R3, with no legacy masking. The banks are fast-interrupt (10001/00001), interrupt (10010/00010), supervisor (10011/00011), abort (10111) and undefined (11011).
- R8: A saved-status write made in user (10000/00000), system (11111) or any other unlisted mode is dropped and changes no saved word.
- R9: A saved-status read whose select names a mode without a saved word returns the current status word.
- R10: The outputs map bit 31 to N, 30 to Z, 29 to C, 28 to V, 7 to interrupt disable, 6 to fast-interrupt disable, 5 to thumb and 4:0 to the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog32_i | input | 1 | High for 32-bit operation, low for legacy 26-bit masking |
| wr_cpsr_i | input | 1 | Current-status write strobe |
| wr_spsr_i | input | 1 | Saved-status write strobe |
| field_mask_i | input | 4 | Field mask taken from instruction bits 19:16 |
| wr_data_i | input | 32 | Write data |
| spsr_rd_mode_i | input | 5 | Mode whose saved word is read |
| spsr_rd_data_o | output | 32 | Saved-status read data |
| cpsr_o | output | 32 | Current status word |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| irq_dis_o | output | 1 | Interrupt disable |
| fiq_dis_o | output | 1 | Fast-interrupt disable |
| thumb_o | output | 1 | Thumb state |
| mode_o | output | 5 | Current mode |
| mode_chg_o | output | 1 | Bank switch request pulse |
| old_mode_o | output | 5 | Mode before the last current-status write |

## Verification
On every cycle the assertions check the following:
- the mode-change pulse appears exactly when a write moved the mode field;
- the status word holds whenever there is no strobe;
- a user-mode write leaves bits 23:0 untouched;
- a legacy-mode write leaves nothing outside the 26-bit keep mask;
- reads of modes without a saved word mirror the current status word.

Some rules involve stored state that the properties cannot see. These are left to the bench's scenarios: which field each mask value selects, routing of saved-status writes to the correct bank, dropped saved-status writes in user and system mode, and the exact reset values.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W    = 32;
  localparam int MODE_W   = 5;
  localparam int MASK_W   = 4;
  localparam int N_SPSR   = 5;
  localparam int FLAG_LSB = 24;
  localparam int CTRL_W   = 8;
  localparam int IDX_W    = $clog2(N_SPSR);

  localparam logic [PSR_W-1:0]  LEGACY_KEEP = 32'hF000_00C3;
  localparam logic [PSR_W-1:0]  RESET_PSR   = 32'h0000_00D3;
  localparam logic [MASK_W-1:0] FULL_MASK   = 4'b1001;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_NONE
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      5'b10000, 5'b00000: return BK_USR;
      5'b10001, 5'b00001: return BK_FIQ;
      5'b10010, 5'b00010: return BK_IRQ;
      5'b10011, 5'b00011: return BK_SVC;
      5'b10111:           return BK_ABT;
      5'b11011:           return BK_UND;
      5'b11111:           return BK_SYS;
      default:            return BK_NONE;
    endcase
  endfunction

  function automatic logic has_spsr(input bank_e b);
    return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
           (b == BK_ABT) || (b == BK_UND);
  endfunction

  // saved slots are numbered from the fast-interrupt bank upward
  function automatic logic [IDX_W-1:0] spsr_idx(input bank_e b);
    logic [2:0] raw;
    raw = 3'(b) - 3'd1;
    return raw[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/psr_merge.sv
module psr_merge
  import psr_pkg::*;
#(
  parameter int W = PSR_W
) (
  input  logic [W-1:0]      cur_i,
  input  logic [W-1:0]      data_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              flags_only_i,
  input  logic              legacy_i,
  output logic [W-1:0]      next_o
);
  logic [W-1:0] sel;
  logic [W-1:0] merged;

  always_comb begin
    sel = '0;
    if (flags_only_i) begin
      sel[W-1:FLAG_LSB] = '1;
    end else if (mask_i == FULL_MASK) begin
      sel = '1;
    end else begin
      if (mask_i[3]) sel[W-1:FLAG_LSB] = '1;
      if (mask_i[0]) sel[CTRL_W-1:0]   = '1;
    end
    merged = (cur_i & ~sel) | (data_i & sel);
    next_o = legacy_i ? (merged & W'(LEGACY_KEEP)) : merged;
  end
endmodule

// File: rtl/spsr_bank.sv
module spsr_bank
  import psr_pkg::*;
#(
  parameter int W = PSR_W,
  parameter int N = N_SPSR
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  bank_e        wr_bank_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] wr_cur_o,
  input  bank_e        rd_bank_i,
  input  logic [W-1:0] cpsr_i,
  output logic [W-1:0] rd_data_o
);
  logic [W-1:0] slots [N];
  logic         wr_ok;

  assign wr_ok = wr_i && has_spsr(wr_bank_i);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= '0;
      else if (wr_ok && (spsr_idx(wr_bank_i) == g[IDX_W-1:0]))
        q <= wr_data_i;
    end
    assign slots[g] = q;
  end

  assign wr_cur_o  = has_spsr(wr_bank_i) ? slots[spsr_idx(wr_bank_i)] : '0;
  assign rd_data_o = has_spsr(rd_bank_i) ? slots[spsr_idx(rd_bank_i)] : cpsr_i;
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog32_i,
  input  logic              wr_cpsr_i,
  input  logic              wr_spsr_i,
  input  logic [MASK_W-1:0] field_mask_i,
  input  logic [PSR_W-1:0]  wr_data_i,
  input  logic [MODE_W-1:0] spsr_rd_mode_i,
  output logic [PSR_W-1:0]  spsr_rd_data_o,
  output logic [PSR_W-1:0]  cpsr_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              irq_dis_o,
  output logic              fiq_dis_o,
  output logic              thumb_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              mode_chg_o,
  output logic [MODE_W-1:0] old_mode_o
);
  logic [PSR_W-1:0]  cpsr_q, cpsr_d;
  logic [PSR_W-1:0]  spsr_cur, spsr_d;
  logic              chg_q;
  logic [MODE_W-1:0] old_mode_q;
  bank_e             cur_bank;

  assign cur_bank = bank_of(cpsr_q[MODE_W-1:0]);

  psr_merge #(.W(PSR_W)) i_cpsr_merge (
    .cur_i        (cpsr_q),
    .data_i       (wr_data_i),
    .mask_i       (field_mask_i),
    .flags_only_i (cur_bank == BK_USR),
    .legacy_i     (!prog32_i),
    .next_o       (cpsr_d)
  );

  psr_merge #(.W(PSR_W)) i_spsr_merge (
    .cur_i        (spsr_cur),
    .data_i       (wr_data_i),
    .mask_i       (field_mask_i),
    .flags_only_i (1'b0),
    .legacy_i     (1'b0),
    .next_o       (spsr_d)
  );

  spsr_bank #(.W(PSR_W), .N(N_SPSR)) i_spsr_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_spsr_i),
    .wr_bank_i (cur_bank),
    .wr_data_i (spsr_d),
    .wr_cur_o  (spsr_cur),
    .rd_bank_i (bank_of(spsr_rd_mode_i)),
    .cpsr_i    (cpsr_q),
    .rd_data_o (spsr_rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q     <= RESET_PSR;
      chg_q      <= 1'b0;
      old_mode_q <= RESET_PSR[MODE_W-1:0];
    end else if (wr_cpsr_i) begin
      cpsr_q     <= cpsr_d;
      chg_q      <= cpsr_d[MODE_W-1:0] != cpsr_q[MODE_W-1:0];
      old_mode_q <= cpsr_q[MODE_W-1:0];
    end else begin
      chg_q      <= 1'b0;
    end
  end

  assign cpsr_o     = cpsr_q;
  assign flag_n_o   = cpsr_q[31];
  assign flag_z_o   = cpsr_q[30];
  assign flag_c_o   = cpsr_q[29];
  assign flag_v_o   = cpsr_q[28];
  assign irq_dis_o  = cpsr_q[7];
  assign fiq_dis_o  = cpsr_q[6];
  assign thumb_o    = cpsr_q[5];
  assign mode_o     = cpsr_q[MODE_W-1:0];
  assign mode_chg_o = chg_q;
  assign old_mode_o = old_mode_q;
endmodule

// File: rtl/psr_ctrl_chk.sv
module psr_ctrl_chk
  import psr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog32_i,
  input logic              wr_cpsr_i,
  input logic [MODE_W-1:0] spsr_rd_mode_i,
  input logic [PSR_W-1:0]  spsr_rd_data_o,
  input logic [PSR_W-1:0]  cpsr_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              mode_chg_o,
  input logic [MODE_W-1:0] old_mode_o
);
  assert_chg_needs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_cpsr_i) |-> !mode_chg_o);

  assert_chg_mode_differs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> (mode_o != old_mode_o));

  assert_no_silent_switch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_cpsr_i) && (mode_o != $past(mode_o))) |-> mode_chg_o);

  assert_hold_without_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_cpsr_i) |-> $stable(cpsr_o));

  assert_user_flags_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_cpsr_i && prog32_i) &&
     ($past(mode_o) == 5'b10000 || $past(mode_o) == 5'b00000))
    |-> (cpsr_o[23:0] == $past(cpsr_o[23:0])));

  assert_legacy_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_cpsr_i && !prog32_i) |-> ((cpsr_o & ~LEGACY_KEEP) == '0));

  assert_nospsr_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spsr_rd_mode_i == 5'b10000 || spsr_rd_mode_i == 5'b11111)
    |-> (spsr_rd_data_o == cpsr_o));
endmodule

bind psr_ctrl psr_ctrl_chk i_psr_ctrl_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .prog32_i       (prog32_i),
  .wr_cpsr_i      (wr_cpsr_i),
  .spsr_rd_mode_i (spsr_rd_mode_i),
  .spsr_rd_data_o (spsr_rd_data_o),
  .cpsr_o         (cpsr_o),
  .mode_o         (mode_o),
  .mode_chg_o     (mode_chg_o),
  .old_mode_o     (old_mode_o)
);

// File: tb/test_psr_ctrl.sv
module test_psr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 10;
  // {prog32, wr_cpsr, wr_spsr, mask[3:0], data[31:0], rd_mode[4:0], exp_cpsr[31:0], exp_chg, exp_rd[31:0]}
  localparam int VEC_W = 1 + 1 + 1 + 4 + 32 + 5 + 32 + 1 + 32;
  localparam logic [VEC_W-1:0] VECS [N_VEC] = '{
    {3'b110, 4'b1001, 32'hF000_0011, 5'b10010, 32'hF000_0011, 1'b1, 32'h0000_0000},
    {3'b110, 4'b0001, 32'hAAAA_AAD2, 5'b10010, 32'hF000_00D2, 1'b1, 32'h0000_0000},
    {3'b110, 4'b1000, 32'h5512_3413, 5'b10010, 32'h5500_00D2, 1'b0, 32'h0000_0000},
    {3'b110, 4'b0110, 32'hFFFF_FFFF, 5'b10010, 32'h5500_00D2, 1'b0, 32'h0000_0000},
    {3'b101, 4'b1001, 32'h1234_5678, 5'b10010, 32'h5500_00D2, 1'b0, 32'h1234_5678},
    {3'b101, 4'b0001, 32'hFFFF_FF00, 5'b10010, 32'h5500_00D2, 1'b0, 32'h1234_5600},
    {3'b110, 4'b1001, 32'h8000_0010, 5'b10010, 32'h8000_0010, 1'b1, 32'h1234_5600},
    {3'b110, 4'b1001, 32'h4FFF_FFDF, 5'b10000, 32'h4F00_0010, 1'b0, 32'h4F00_0010},
    {3'b110, 4'b0000, 32'h2000_0013, 5'b11111, 32'h2000_0010, 1'b0, 32'h2000_0010},
    {3'b101, 4'b1001, 32'hDEAD_BEEF, 5'b10010, 32'h2000_0010, 1'b0, 32'h1234_5600}
  };
  localparam string VEC_REQ [N_VEC] = '{"R2", "R3", "R3", "R3", "R7",
                                        "R7", "R2", "R4", "R4", "R8"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog32_i = 1'b1;
  logic        wr_cpsr_i = 1'b0;
  logic        wr_spsr_i = 1'b0;
  logic [3:0]  field_mask_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  spsr_rd_mode_i = 5'b10011;
  logic [31:0] spsr_rd_data_o, cpsr_o;
  logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o;
  logic        irq_dis_o, fiq_dis_o, thumb_o, mode_chg_o;
  logic [4:0]  mode_o, old_mode_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psr_ctrl i_psr_ctrl (
    .clk_i, .rst_ni, .prog32_i, .wr_cpsr_i, .wr_spsr_i, .field_mask_i,
    .wr_data_i, .spsr_rd_mode_i, .spsr_rd_data_o, .cpsr_o, .flag_n_o,
    .flag_z_o, .flag_c_o, .flag_v_o, .irq_dis_o, .fiq_dis_o, .thumb_o,
    .mode_o, .mode_chg_o, .old_mode_o
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge apply it, return at the next falling edge
  task automatic op(input logic p32, input logic wc, input logic ws,
                    input logic [3:0] m, input logic [31:0] d, input logic [4:0] rdm);
    @(negedge clk_i);
    prog32_i = p32; wr_cpsr_i = wc; wr_spsr_i = ws;
    field_mask_i = m; wr_data_i = d; spsr_rd_mode_i = rdm;
    @(negedge clk_i);
    wr_cpsr_i = 1'b0; wr_spsr_i = 1'b0;
    #1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1", "reset cpsr", cpsr_o, 32'h0000_00D3);
    check("R1", "reset chg", {31'b0, mode_chg_o}, 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [VEC_W-1:0] v;
      v = VECS[i];
      op(v[VEC_W-1], v[VEC_W-2], v[VEC_W-3], v[VEC_W-4 -: 4], v[VEC_W-8 -: 32], v[VEC_W-40 -: 5]);
      check(VEC_REQ[i], $sformatf("vec %0d cpsr", i), cpsr_o, v[VEC_W-45 -: 32]);
      check("R6", $sformatf("vec %0d chg", i), {31'b0, mode_chg_o}, {31'b0, v[32]});
      check(VEC_REQ[i], $sformatf("vec %0d spsr read", i), spsr_rd_data_o, v[31:0]);
    end

    // R1: reset clears everything again
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1; spsr_rd_mode_i = 5'b10010; #1;
    check("R1", "reset cpsr again", cpsr_o, 32'h0000_00D3);
    check("R1", "reset spsr irq", spsr_rd_data_o, 32'h0);

    // R5: legacy masking, mode moves 10011 -> 00011
    op(1'b0, 1'b1, 1'b0, 4'b1001, 32'hFFFF_FFFF, 5'b10011);
    check("R5", "legacy cpsr", cpsr_o, 32'hF000_00C3);
    check("R6", "legacy chg", {31'b0, mode_chg_o}, 32'h1);
    check("R6", "old mode", {27'b0, old_mode_o}, 32'h13);
    check("R10", "flags nzcv", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 32'hF);
    check("R10", "int bits", {29'b0, irq_dis_o, fiq_dis_o, thumb_o}, 32'h6);
    check("R10", "mode", {27'b0, mode_o}, 32'h03);

    // R7: legacy supervisor bank still has a saved word, no legacy masking there
    op(1'b0, 1'b0, 1'b1, 4'b1001, 32'hFFFF_FFFF, 5'b10011);
    check("R7", "svc spsr", spsr_rd_data_o, 32'hFFFF_FFFF);
    check("R6", "chg drops", {31'b0, mode_chg_o}, 32'h0);

    // system mode with thumb set
    op(1'b1, 1'b1, 1'b0, 4'b1001, 32'h0000_003F, 5'b11111);
    check("R2", "system cpsr", cpsr_o, 32'h0000_003F);
    check("R10", "thumb", {31'b0, thumb_o}, 32'h1);
    check("R9", "system read", spsr_rd_data_o, 32'h0000_003F);

    // R8: system has no saved word
    op(1'b1, 1'b0, 1'b1, 4'b1001, 32'h0000_0001, 5'b10011);
    check("R8", "svc spsr kept", spsr_rd_data_o, 32'hFFFF_FFFF);
    check("R8", "cpsr kept", cpsr_o, 32'h0000_003F);

    // R3: system is privileged, flags field only
    op(1'b1, 1'b1, 1'b0, 4'b1000, 32'hA000_0000, 5'b10111);
    check("R3", "system flags", cpsr_o, 32'hA000_003F);

    // abort bank
    op(1'b1, 1'b1, 1'b0, 4'b0001, 32'h0000_0017, 5'b10111);
    check("R3", "abort cpsr", cpsr_o, 32'hA000_0017);
    op(1'b1, 1'b0, 1'b1, 4'b1000, 32'h7000_0000, 5'b10111);
    check("R7", "abort spsr", spsr_rd_data_o, 32'h7000_0000);
    spsr_rd_mode_i = 5'b11011; #1;
    check("R7", "undef spsr untouched", spsr_rd_data_o, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule